// File: doc/BRIEF.md
# Secure-Mode System Register Access Unit

This unit holds two processor control registers behind one access port and decides, for every access, whether it may go ahead. One register is a 32-bit monitor vector base that software programs. The other is a read-only interrupt status word. That word reports the live level of the fast and normal interrupt request pins and of an external abort line. Each access carries the current security state (secure or nonsecure) and privilege level (privileged or user). A write-lock input can also freeze the vector base register against writes made from the secure side.

An access that the current mode may not make does not touch any state. Instead it raises a one-cycle undefined-instruction fault, in the same cycle as the offending strobe. During that cycle the read data is forced to zero. The unit does not decode instructions and does not take exceptions; it only reports the fault.

Top module: `sysreg_access_unit`

## Requirements
- R1: After reset, a secure privileged read of the vector base register (select value 0) returns all zeros.
- R2: A secure privileged write to the vector base register with the lock input low stores the write data at the next rising edge. A read in the following cycle returns that value, and the strobe cycle shows no fault.
- R3: Any read or write of the vector base register from nonsecure privileged, secure user or nonsecure user mode raises the fault and leaves the register unchanged.
- R4: While the lock input is high in the strobe cycle, a secure privileged write to the vector base register faults and leaves the register unchanged. The lock input has no effect on reads.
- R5: A privileged read of the status register (select value 1), from either security state, returns the following word. Bit 8 is 1 while the abort line is high. Bit 7 is 1 while the active-low normal interrupt pin is low. Bit 6 is 1 while the active-low fast interrupt pin is low. All other bits read as 0.
- R6: Any user-mode access to the status register faults and returns zero read data.
- R7: A privileged write to the status register faults.
- R8: The fault output is high only in a cycle with a read or write strobe. Read data is zero during a fault and in every cycle without a permitted read.
- R9: The three status inputs each pass through two flip-flops. A level change first appears in a read made after the second rising edge that follows the change.
- R10: When the read and write strobes are both high, the access is treated as a write only. Its permission follows the write rules and the read data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Register select: 0 vector base, 1 interrupt status |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| secure_i | input | 1 | 1 when the current state is secure |
| priv_i | input | 1 | 1 when the current mode is privileged |
| wlock_i | input | 1 | Blocks secure writes to the vector base register while high |
| fiq_n_i | input | 1 | Fast interrupt request pin, active low |
| irq_n_i | input | 1 | Normal interrupt request pin, active low |
| ext_abort_i | input | 1 | External abort pending, active high |
| rdata_o | output | 32 | Read data, zero unless a permitted read is made |
| undef_o | output | 1 | Undefined-instruction fault pulse |

## Verification
The assertions check every cycle that a fault only comes with a strobe, and that a fault or a missing read gives zero data. They check that user accesses always fault and that a faulted write leaves the vector base register as it was. They check that a permitted write lands one edge later and that each status bit follows its pin with a two-edge delay. The bench's scenarios show the values software sees: the reset value, written data read back across mode changes, and the status word under different pin patterns. They also show the exact read in which a pin change first becomes visible, and how the lock input interacts with a read and write made together.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;

  typedef enum logic {
    SEL_VBASE = 1'b0,
    SEL_ISTAT = 1'b1
  } reg_sel_e;

  typedef struct packed {
    logic abort_act;
    logic irq_act;
    logic fiq_act;
  } istat_bits_t;

  // Assemble the status word from the synchronized active-high levels.
  function automatic logic [31:0] pack_istat(input istat_bits_t b,
                                             input int abort_pos,
                                             input int irq_pos,
                                             input int fiq_pos);
    logic [31:0] w;
    w = '0;
    w[abort_pos] = b.abort_act;
    w[irq_pos]   = b.irq_act;
    w[fiq_pos]   = b.fiq_act;
    return w;
  endfunction

endpackage

// File: rtl/sysreg_perm_check.sv
module sysreg_perm_check
  import sysreg_pkg::*;
(
  input  logic     rd_i,
  input  logic     wr_i,
  input  reg_sel_e sel_i,
  input  logic     secure_i,
  input  logic     priv_i,
  input  logic     wlock_i,
  output logic     rd_ok_o,
  output logic     vbase_we_o,
  output logic     fault_o
);

  logic any_acc;
  logic is_wr;
  logic is_rd;
  logic allowed;

  assign any_acc = rd_i | wr_i;
  assign is_wr   = wr_i;            // a write wins over a simultaneous read
  assign is_rd   = rd_i & ~wr_i;

  always_comb begin
    unique case (sel_i)
      SEL_VBASE: allowed = secure_i & priv_i & ~(is_wr & wlock_i);
      SEL_ISTAT: allowed = priv_i & ~is_wr;
      default:   allowed = 1'b0;
    endcase
  end

  assign fault_o    = any_acc & ~allowed;
  assign rd_ok_o    = is_rd & allowed;
  assign vbase_we_o = is_wr & allowed & (sel_i == SEL_VBASE);

endmodule

// File: rtl/sysreg_vbase.sv
module sysreg_vbase #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else if (we_i) q_o <= wdata_i;
  end

endmodule

// File: rtl/sysreg_level_sync.sv
module sysreg_level_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else chain[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else chain[s] <= chain[s-1];
    end
  end

  assign q_o = chain[STAGES-1];

endmodule

// File: rtl/sysreg_access_unit.sv
module sysreg_access_unit
  import sysreg_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter int ABORT_POS   = 8,
  parameter int IRQ_POS     = 7,
  parameter int FIQ_POS     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              secure_i,
  input  logic              priv_i,
  input  logic              wlock_i,
  input  logic              fiq_n_i,
  input  logic              irq_n_i,
  input  logic              ext_abort_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              undef_o
);

  localparam int NSRC = 3;

  reg_sel_e          sel;
  logic              rd_ok;
  logic              vbase_we;
  logic              fault;
  logic [DATA_W-1:0] vbase_q;
  logic [NSRC-1:0]   raw_act;
  logic [NSRC-1:0]   sync_act;
  istat_bits_t       istat;
  logic [31:0]       istat_word;

  assign sel = reg_sel_e'(sel_i);

  sysreg_perm_check u_perm (
    .rd_i      (rd_i),
    .wr_i      (wr_i),
    .sel_i     (sel),
    .secure_i  (secure_i),
    .priv_i    (priv_i),
    .wlock_i   (wlock_i),
    .rd_ok_o   (rd_ok),
    .vbase_we_o(vbase_we),
    .fault_o   (fault)
  );

  sysreg_vbase #(.DATA_W(DATA_W)) u_vbase (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_i   (vbase_we),
    .wdata_i(wdata_i),
    .q_o    (vbase_q)
  );

  // Pins are inverted to active-high before synchronizing so reset means idle.
  assign raw_act = {ext_abort_i, ~irq_n_i, ~fiq_n_i};

  sysreg_level_sync #(.WIDTH(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (raw_act),
    .q_o  (sync_act)
  );

  assign istat      = istat_bits_t'(sync_act);
  assign istat_word = pack_istat(istat, ABORT_POS, IRQ_POS, FIQ_POS);

  always_comb begin
    rdata_o = '0;
    if (rd_ok) begin
      if (sel == SEL_VBASE) rdata_o = vbase_q;
      else                  rdata_o = DATA_W'(istat_word);
    end
  end

  assign undef_o = fault;

  // ---------------- assertions ----------------
  logic [1:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  AST_FAULT_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    undef_o |-> (rd_i | wr_i)); // R8

  AST_FAULT_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (undef_o | ~rd_i | wr_i) |-> (rdata_o == '0)); // R8

  AST_USER_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_i | wr_i) & ~priv_i) |-> undef_o); // R6

  AST_NONSEC_VBASE_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_i | wr_i) & ~secure_i & (sel == SEL_VBASE)) |-> undef_o); // R3

  AST_ISTAT_WRITE_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i & (sel == SEL_ISTAT)) |-> undef_o); // R7

  AST_FAULTED_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i & undef_o) |=> $stable(vbase_q)); // R4

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i & ~undef_o & (sel == SEL_VBASE)) |=> (vbase_q == $past(wdata_i))); // R2

  AST_LOCK_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i & wlock_i & (sel == SEL_VBASE)) |-> undef_o); // R4

  AST_ISTAT_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i & ~wr_i & ~undef_o & (sel == SEL_ISTAT)) |->
      ($countones(rdata_o) == $countones({rdata_o[ABORT_POS], rdata_o[IRQ_POS], rdata_o[FIQ_POS]}))); // R5

  if (SYNC_STAGES == 2) begin : g_sync_chk
    AST_IRQ_TWO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc == 2'd3) |-> (istat.irq_act == ~$past(irq_n_i, 2))); // R9
    AST_FIQ_TWO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc == 2'd3) |-> (istat.fiq_act == ~$past(fiq_n_i, 2))); // R9
  end

endmodule

// File: tb/sim_sysreg_access_unit.sv
module sim_sysreg_access_unit;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sel, rd, wr, sec, priv, lock;
  logic [31:0] wdata;
  logic        fiq_n, irq_n, abrt;
  logic [31:0] rdata;
  logic        undef;

  int checks = 0;
  int failures = 0;
  logic [31:0] m_vbase;
  logic [31:0] m_stat;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysreg_access_unit u0 (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .secure_i(sec), .priv_i(priv), .wlock_i(lock),
    .fiq_n_i(fiq_n), .irq_n_i(irq_n), .ext_abort_i(abrt),
    .rdata_o(rdata), .undef_o(undef)
  );

  function automatic logic [31:0] stat_of(input logic ab, input logic irqn, input logic fiqn);
    logic [31:0] w = 32'h0;
    if (ab)    w = w | 32'h100;
    if (!irqn) w = w | 32'h080;
    if (!fiqn) w = w | 32'h040;
    return w;
  endfunction

  task automatic check(input string req, input logic [31:0] act_d, input logic [31:0] exp_d,
                       input logic act_f, input logic exp_f);
    checks++;
    if (act_d !== exp_d || act_f !== exp_f) begin
      failures++;
      $display("FAIL %s rdata=%h/undef=%b expected rdata=%h/undef=%b", req, act_d, act_f, exp_d, exp_f);
    end
  endtask

  // Drive one access; sample at the falling edge; release after the next rising edge.
  task automatic access(input string req, input logic s, input logic r, input logic w,
                        input logic [31:0] d, input logic sc, input logic pv, input logic lk);
    logic allowed, acc, fexp;
    logic [31:0] dexp;
    sel = s; rd = r; wr = w; wdata = d; sec = sc; priv = pv; lock = lk;
    acc = r | w;
    if (s == 1'b0) allowed = sc & pv & ~(w & lk);
    else           allowed = pv & ~w;
    fexp = acc & ~allowed;
    dexp = (r & ~w & allowed) ? (s ? m_stat : m_vbase) : 32'h0;
    @(negedge clk);
    check(req, rdata, dexp, undef, fexp);
    @(posedge clk);
    #1;
    if (w & allowed & (s == 1'b0)) m_vbase = d;
    rd = 0; wr = 0;
  endtask

  task automatic set_pins(input logic ab, input logic irqn, input logic fiqn);
    abrt = ab; irq_n = irqn; fiq_n = fiqn;
    repeat (3) @(posedge clk);
    #1;
    m_stat = stat_of(ab, irqn, fiqn);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] old_stat;
    rst_n = 0; sel = 0; rd = 0; wr = 0; wdata = 0; sec = 0; priv = 0; lock = 0;
    fiq_n = 1; irq_n = 1; abrt = 0;
    m_vbase = 0; m_stat = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;

    // R1 reset values
    access("R1 reset vbase", 0, 1, 0, 0, 1, 1, 0);
    access("R5 reset status", 1, 1, 0, 0, 1, 1, 0);
    // R8 idle cycle
    access("R8 idle", 0, 0, 0, 32'hFFFF_FFFF, 1, 1, 0);
    // R2 write then read back
    access("R2 write", 0, 0, 1, 32'hDEAD_BEEF, 1, 1, 0);
    access("R2 readback", 0, 1, 0, 0, 1, 1, 0);
    // R3 other modes
    access("R3 ns priv write", 0, 0, 1, 32'h1111_1111, 0, 1, 0);
    access("R3 sec user read", 0, 1, 0, 0, 1, 0, 0);
    access("R3 ns user write", 0, 0, 1, 32'h2222_2222, 0, 0, 0);
    access("R3 unchanged", 0, 1, 0, 0, 1, 1, 0);
    // R4 lock
    access("R4 locked write", 0, 0, 1, 32'h3333_3333, 1, 1, 1);
    access("R4 read under lock", 0, 1, 0, 0, 1, 1, 1);
    // R10 both strobes
    access("R10 both strobes", 0, 1, 1, 32'h4444_4444, 1, 1, 0);
    access("R10 readback", 0, 1, 0, 0, 1, 1, 0);
    access("R10 both locked", 0, 1, 1, 32'h5555_5555, 1, 1, 1);
    // R5 status patterns
    set_pins(1, 0, 1);
    access("R5 abort+irq nonsecure", 1, 1, 0, 0, 0, 1, 0);
    set_pins(0, 1, 0);
    access("R5 fiq secure", 1, 1, 0, 0, 1, 1, 1);
    // R6 R7
    access("R6 user status read", 1, 1, 0, 0, 1, 0, 0);
    access("R7 priv status write", 1, 0, 1, 32'hFFFF_FFFF, 1, 1, 0);
    // R9 synchronizer latency
    old_stat = m_stat;
    abrt = 1; irq_n = 0; fiq_n = 1;
    access("R9 before first edge", 1, 1, 0, 0, 1, 1, 0);
    access("R9 after one edge", 1, 1, 0, 0, 1, 1, 0);
    m_stat = stat_of(1, 0, 1);
    access("R9 after two edges", 1, 1, 0, 0, 1, 1, 0);
    if (old_stat == m_stat) $display("note: R9 pattern unchanged");

    // random mix
    void'($urandom(32'd1234));
    for (int i = 0; i < 400; i++) begin
      logic [2:0] op;
      if (i % 25 == 0) set_pins(1'($urandom), 1'($urandom), 1'($urandom));
      op = 3'($urandom % 8);
      access("R2/R3/R4/R5/R10 random", 1'($urandom), op[0] | op[2], op[1],
             $urandom, 1'($urandom), 1'($urandom), ($urandom % 4) == 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule